// File: doc/BRIEF.md
# Predicated Write-Back Condition Evaluator

This block decides, once per cycle, whether the result of the instruction in flight may be committed to its destination. An extended instruction carries a seven-bit condition field: a four-bit condition register address, a two-bit function code and a negate bit. The register address picks one of two tables. Address 0 selects tests on processor flags: unconditional, shadow, carry and equal. Addresses 1 to 15 select tests on the value read from that register: non-zero, shadow non-zero, odd and top bit set. The negate bit inverts whichever test is chosen. The encoding is arranged so that an all-zero field means "always". Instructions without a condition field commit unconditionally.

The evaluated enable is registered, so it becomes visible one cycle after its inputs are sampled. It then feeds the stage that suppresses the write. A negated "always" is the reserved "never" encoding. It blocks the write and also raises an illegal-condition flag. Reading the register file and producing the flags are done elsewhere. The shadow input can be tied to a copy of R1 in a first implementation.

Top module: `pred_commit_eval`

## Requirements
- R1: While rst_ni is low, wr_en_o and illegal_o are both 0.
- R2: When ext_i is 0, wr_en_o is 1 and illegal_o is 0, whatever the condition inputs.
- R3: For cnd_reg_i in 1..15, function code 2'b00 gives true when reg_val_i is non-zero.
- R4: Function code 2'b01 gives true when shadow_i is non-zero, for every cnd_reg_i including 0.
- R5: For cnd_reg_i in 1..15, function code 2'b10 gives true when bit 0 of reg_val_i is 1.
- R6: For cnd_reg_i in 1..15, function code 2'b11 gives true when bit DATA_W-1 of reg_val_i is 1. No other bit affects this test.
- R7: With cnd_reg_i 0 and function code 2'b00, the test is always true. An all-zero condition field (cnd_neg_i 0) therefore sets wr_en_o.
- R8: With cnd_reg_i 0 and function code 2'b10, the test equals carry_i.
- R9: With cnd_reg_i 0 and function code 2'b11, the test equals equal_i.
- R10: When cnd_neg_i is 1, wr_en_o is the inverse of the selected test.
- R11: cnd_reg_i 0, function code 2'b00 and cnd_neg_i 1 ("never") drive wr_en_o to 0 and illegal_o to 1. illegal_o is 0 for every other input combination.
- R12: wr_en_o and illegal_o reflect the inputs sampled at the previous rising clock edge, and they hold between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | 1 | Instruction carries a condition field |
| cnd_reg_i | input | 4 | Condition register address |
| cnd_fn_i | input | 2 | Condition function code |
| cnd_neg_i | input | 1 | Negate the selected test |
| reg_val_i | input | DATA_W | Value read from the condition register |
| shadow_i | input | DATA_W | Shadow value |
| carry_i | input | 1 | Carry flag |
| equal_i | input | 1 | Equal flag |
| wr_en_o | output | 1 | Result may be committed |
| illegal_o | output | 1 | Reserved "never" encoding seen |

## Verification
The only state is the output register. A wrong evaluation therefore shows on wr_en_o or illegal_o exactly one cycle after the offending inputs, and it cannot persist beyond the next edge. A mis-selected table shows when the same function code is applied with register 0 and with a non-zero register under opposite flag and register values. A wrong bit index in the top-bit test shows only with values whose bit DATA_W-1 and lower bits disagree, so those values are applied explicitly.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    FN_BASE  = 2'b00,  // non-zero / always
    FN_SHAD  = 2'b01,
    FN_LOW   = 2'b10,  // lsb / carry
    FN_HIGH  = 2'b11   // msb / equal
  } cnd_fn_e;

  localparam int unsigned CND_REG_W = 4;
endpackage

// File: rtl/pred_reg_test.sv
module pred_reg_test
  import pred_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  cnd_fn_e           fn_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              shadow_nz_i,
  output logic              hit_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    unique case (fn_i)
      FN_BASE: hit_o = |val_i;
      FN_SHAD: hit_o = shadow_nz_i;
      FN_LOW:  hit_o = val_i[0];
      FN_HIGH: hit_o = val_i[MSB];
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_flag_test.sv
module pred_flag_test
  import pred_pkg::*;
(
  input  cnd_fn_e fn_i,
  input  logic    shadow_nz_i,
  input  logic    carry_i,
  input  logic    equal_i,
  output logic    hit_o,
  output logic    always_o
);
  always_comb begin
    always_o = (fn_i == FN_BASE);
    unique case (fn_i)
      FN_BASE: hit_o = 1'b1;
      FN_SHAD: hit_o = shadow_nz_i;
      FN_LOW:  hit_o = carry_i;
      FN_HIGH: hit_o = equal_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_commit_eval.sv
module pred_commit_eval
  import pred_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic [3:0]        cnd_reg_i,
  input  logic [1:0]        cnd_fn_i,
  input  logic              cnd_neg_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] shadow_i,
  input  logic              carry_i,
  input  logic              equal_i,
  output logic              wr_en_o,
  output logic              illegal_o
);
  cnd_fn_e fn;
  logic    shadow_nz;
  logic    flag_sel;
  logic    reg_hit, flag_hit, flag_always;
  logic    sel_hit, never_d, we_d;
  logic    we_q, ill_q, seen_q;

  assign fn        = cnd_fn_e'(cnd_fn_i);
  assign shadow_nz = |shadow_i;
  assign flag_sel  = (cnd_reg_i == '0);

  pred_reg_test #(.DATA_W(DATA_W)) u_reg (
    .fn_i        (fn),
    .val_i       (reg_val_i),
    .shadow_nz_i (shadow_nz),
    .hit_o       (reg_hit)
  );

  pred_flag_test u_flag (
    .fn_i        (fn),
    .shadow_nz_i (shadow_nz),
    .carry_i     (carry_i),
    .equal_i     (equal_i),
    .hit_o       (flag_hit),
    .always_o    (flag_always)
  );

  always_comb begin
    sel_hit = flag_sel ? flag_hit : reg_hit;
    never_d = ext_i && flag_sel && flag_always && cnd_neg_i;
    we_d    = !ext_i || (sel_hit ^ cnd_neg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      ill_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      ill_q  <= never_d;
      seen_q <= 1'b1;
    end
  end

  assign wr_en_o   = we_q;
  assign illegal_o = ill_q;

  // R2
  nonext_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(ext_i)) |-> (wr_en_o && !illegal_o));

  // R11
  never_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o);

  // R7
  always_commits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(ext_i) && $past(cnd_reg_i) == 4'd0 &&
     $past(cnd_fn_i) == 2'b00 && !$past(cnd_neg_i)) |-> (wr_en_o && !illegal_o));

  // R8
  carry_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(ext_i) && $past(cnd_reg_i) == 4'd0 && $past(cnd_fn_i) == 2'b10)
      |-> (wr_en_o == ($past(carry_i) ^ $past(cnd_neg_i))));

  // R6
  msb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(ext_i) && $past(cnd_reg_i) != 4'd0 && $past(cnd_fn_i) == 2'b11)
      |-> (wr_en_o == ($past(reg_val_i[DATA_W-1]) ^ $past(cnd_neg_i))));
endmodule

// File: tb/pred_commit_eval_test.sv
module pred_commit_eval_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext = 1'b0;
  logic [3:0]   creg = '0;
  logic [1:0]   fn = '0;
  logic         neg = 1'b0;
  logic [W-1:0] rval = '0;
  logic [W-1:0] shad = '0;
  logic         carry = 1'b0;
  logic         equal = 1'b0;
  logic         we, ill;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  pred_commit_eval #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_i(ext), .cnd_reg_i(creg), .cnd_fn_i(fn),
    .cnd_neg_i(neg), .reg_val_i(rval), .shadow_i(shad), .carry_i(carry),
    .equal_i(equal), .wr_en_o(we), .illegal_o(ill)
  );

  task automatic chk(input string req, input logic exp_we, input logic exp_ill);
    checks++;
    if (we !== exp_we || ill !== exp_ill) begin
      errors++;
      $display("FAIL %s: wr_en=%b illegal=%b expected wr_en=%b illegal=%b",
               req, we, ill, exp_we, exp_ill);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run(input string req, input logic e, input logic [3:0] r,
                     input logic [1:0] f, input logic n, input logic [W-1:0] v,
                     input logic [W-1:0] s, input logic c, input logic q,
                     input logic exp_we, input logic exp_ill);
    @(negedge clk);
    ext = e; creg = r; fn = f; neg = n; rval = v; shad = s; carry = c; equal = q;
    @(negedge clk);
    chk(req, exp_we, exp_ill);
  endtask

  task automatic t_reset;
    ext = 1'b1; creg = 4'd0; fn = 2'b00; neg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_nonext;
    run("R2", 1'b0, 4'd0, 2'b00, 1'b1, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R2", 1'b0, 4'd5, 2'b00, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_nonzero;
    run("R3", 1'b1, 4'd3, 2'b00, 1'b0, 32'h0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R3", 1'b1, 4'd3, 2'b00, 1'b0, 32'h100, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R3", 1'b1, 4'd15, 2'b00, 1'b0, 32'h8000_0000, '0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_shadow;
    run("R4", 1'b1, 4'd7, 2'b01, 1'b0, 32'hFFFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R4", 1'b1, 4'd7, 2'b01, 1'b0, 32'h0, 32'h4, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R4", 1'b1, 4'd0, 2'b01, 1'b0, 32'h0, 32'h10, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R4", 1'b1, 4'd0, 2'b01, 1'b0, 32'h1, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_lsb;
    run("R5", 1'b1, 4'd2, 2'b10, 1'b0, 32'h6, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R5", 1'b1, 4'd2, 2'b10, 1'b0, 32'h7, '0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_msb;
    run("R6", 1'b1, 4'd9, 2'b11, 1'b0, 32'h8000_0000, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R6", 1'b1, 4'd9, 2'b11, 1'b0, 32'h7FFF_FFFF, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R6", 1'b1, 4'd9, 2'b11, 1'b0, 32'h0000_8000, '0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_always;
    run("R7", 1'b1, 4'd0, 2'b00, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_carry;
    run("R8", 1'b1, 4'd0, 2'b10, 1'b0, 32'h1, 32'h1, 1'b1, 1'b0, 1'b1, 1'b0);
    run("R8", 1'b1, 4'd0, 2'b10, 1'b0, 32'h1, 32'h1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_equal;
    run("R9", 1'b1, 4'd0, 2'b11, 1'b0, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 1'b1, 1'b0);
    run("R9", 1'b1, 4'd0, 2'b11, 1'b0, 32'hFFFF_FFFF, '0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_negate;
    run("R10", 1'b1, 4'd3, 2'b00, 1'b1, 32'h0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R10", 1'b1, 4'd2, 2'b10, 1'b1, 32'h6, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R10", 1'b1, 4'd0, 2'b10, 1'b1, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R10", 1'b1, 4'd0, 2'b11, 1'b1, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R10", 1'b1, 4'd4, 2'b01, 1'b1, '0, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_never;
    run("R11", 1'b1, 4'd0, 2'b00, 1'b1, 32'hFF, 32'hFF, 1'b1, 1'b1, 1'b0, 1'b1);
    run("R11", 1'b1, 4'd1, 2'b00, 1'b1, 32'hFF, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    run("R12", 1'b1, 4'd0, 2'b00, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk);
    #1;
    ext = 1'b1; creg = 4'd0; fn = 2'b00; neg = 1'b1;
    #2;
    chk("R12", 1'b1, 1'b0);
    @(posedge clk);
    #1;
    chk("R12", 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_nonext();
    t_nonzero();
    t_shadow();
    t_lsb();
    t_msb();
    t_always();
    t_carry();
    t_equal();
    t_negate();
    t_never();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule